// File: doc/BRIEF.md
# Prescaled Time-Base Counter with Modulus Reset

This block is the time base shared by a set of capture and compare channels. A 16-bit up-counter advances by one on every prescaled tick while its run bit is set, and otherwise holds. A divider in front of it slows the system clock by a power of two chosen with a 3-bit code. A one-cycle tick strobe goes out with the count value, so each channel can compare exactly once per count step. When the counter wraps from all ones to zero, a sticky overflow flag is raised. When its enable is set, that flag drives an interrupt request.

The counter can also run as a modulus counter. When the modulus enable is set, a compare-match strobe from channel 7 returns the counter to zero on the next tick instead of letting it increment. The period is then the match value plus one count. A small register port gives software access to the count, the control bits and the flag. Reads are combinational and return all 16 counter bits in one access, so a value is never torn across two reads. Writes take effect at the next clock edge. All pins are plain control and status pins, with no streaming handshake.

Top module: `tmr_timebase`

## Requirements
- R1: After reset the count is 0, all control bits are 0 (counter stopped), the overflow flag is 0, and irq_o and tick_o are low.
- R2: While the run bit is 1 the count rises by exactly one on each cycle in which tick_o is high. While the run bit is 0 the count holds its value.
- R3: Prescale code c (control bits 3:1) divides the clock by 2^c for c = 0 to 5. The reserved codes 6 and 7 divide by 32. Starting from a stopped counter with a cleared divider, n clock edges after the enabling write the count equals floor(n / divisor).
- R4: A control write that changes the prescale code restarts the divider. With the new divisor N, the first count step after that write lands N edges after the write edge, whatever the divider held before.
- R5: tick_o is high for one cycle per count step. For divisors above 1 it is never high in two consecutive cycles. It never pulses while the run bit is 0.
- R6: An increment from 0xFFFF to 0x0000 sets the overflow flag (status register bit 0). A return to zero caused by the modulus reset does not set it.
- R7: Writing a status word with bit 0 = 1 clears the overflow flag, and writing bit 0 = 0 leaves it unchanged. If a wrap and a clearing write fall in the same cycle, the flag stays set.
- R8: irq_o is high exactly when the overflow flag and the overflow interrupt enable (control bit 4) are both 1.
- R9: With the modulus enable (control bit 5) at 1, a tick cycle in which cmp7_match_i is high loads 0 into the count. With the modulus enable at 0, cmp7_match_i is ignored and the counter free-runs.
- R10: Register address 0 reads all 16 count bits in one access. A write to address 0 loads the count at the next edge and takes priority over a tick in the same cycle.
- R11: Address 1 holds the control word {modulus enable, interrupt enable, prescale code[2:0], run} in bits 5:0 and reads back what was written. Address 2 reads the flag in bit 0. Address 3 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 count, 1 control, 2 status, 3 unused) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from reg_addr |
| cmp7_match_i | input | 1 | Compare-match strobe from channel 7 |
| count_o | output | 16 | Current count value |
| tick_o | output | 1 | One-cycle strobe in each cycle that advances the count |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
On every clock, the assertions check the counter's step rules: it holds when there is no tick or load, steps by one on a plain tick, goes to zero on a modulus match, and takes the loaded value on a write. They also check that the flag is set by a wrap, cleared by a 1 written to it and otherwise kept, and that the divider cannot tick right after a code change or tick in two consecutive cycles. The exact divide ratio for each of the eight codes, including the two reserved ones, can only be seen over the bench's timed runs. The same holds for the modulus period, the readback layout of the control and status words, and the priority between a wrap and a clearing write.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int SEL_W     = 3;
  localparam int MAX_SHIFT = 5;

  typedef enum logic [1:0] {
    ADDR_COUNT = 2'd0,
    ADDR_CTRL  = 2'd1,
    ADDR_STAT  = 2'd2,
    ADDR_NONE  = 2'd3
  } reg_addr_e;

  // control word, bit 0 is the run bit
  typedef struct packed {
    logic             mod_en;
    logic             ovf_ie;
    logic [SEL_W-1:0] psel;
    logic             run;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int SEL_W     = tmr_pkg::SEL_W,
  parameter int MAX_SHIFT = tmr_pkg::MAX_SHIFT,
  localparam int DIV_W    = (MAX_SHIFT < 1) ? 1 : MAX_SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] psel,
  input  logic             restart,
  output logic             tick
);

  logic [DIV_W-1:0] div_cnt;
  logic [DIV_W-1:0] limit;
  int               shift;

  // codes beyond the largest shift saturate to it
  always_comb begin
    shift = (int'(psel) > MAX_SHIFT) ? MAX_SHIFT : int'(psel);
    limit = DIV_W'((1 << shift) - 1);
  end

  assign tick = run && (div_cnt >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n)                div_cnt <= '0;
    else if (!run || restart)  div_cnt <= '0;
    else if (div_cnt >= limit) div_cnt <= '0;
    else                       div_cnt <= div_cnt + 1'b1;
  end

  // R4: a code change pushes the next tick a full new period away
  assert_restart_delay_R4: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!tick || limit == '0));

  // R5: with a divisor above one, ticks are never back to back
  assert_tick_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !restart && limit != '0 |=> !tick);

endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             mod_en,
  input  logic             match,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);

  logic mod_hit;

  assign mod_hit = mod_en && match;
  assign wrap    = tick && !load && !mod_hit && (&count);

  always_ff @(posedge clk) begin
    if (!rst_n)       count <= '0;
    else if (load)    count <= load_val;
    else if (tick) begin
      if (mod_hit)    count <= '0;
      else            count <= count + 1'b1;
    end
  end

  // R2: no tick and no load means no change
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !load |=> $stable(count));

  // R2: a plain tick steps by exactly one
  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !load && !mod_hit |=> count == CNT_W'($past(count) + 1'b1));

  // R9: modulus match returns to zero
  assert_modulus_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !load && mod_en && match |=> count == '0);

  // R10: a register load wins over a tick
  assert_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> count == $past(load_val));

endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  input  logic [CNT_W-1:0] count,
  input  logic             wrap,
  output ctrl_t            ctrl,
  output logic             restart,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output logic             ovf_flag,
  output logic             irq,
  output logic [CNT_W-1:0] reg_rdata
);

  reg_addr_e addr;
  ctrl_t     ctrl_new;
  logic      ctrl_wr;
  logic      stat_clr;

  assign addr     = reg_addr_e'(reg_addr);
  assign ctrl_new = ctrl_t'(reg_wdata[CTRL_W-1:0]);
  assign ctrl_wr  = reg_wr && (addr == ADDR_CTRL);
  assign stat_clr = reg_wr && (addr == ADDR_STAT) && reg_wdata[0];
  assign load     = reg_wr && (addr == ADDR_COUNT);
  assign load_val = reg_wdata;
  assign restart  = ctrl_wr && (ctrl_new.psel != ctrl.psel);
  assign irq      = ovf_flag && ctrl.ovf_ie;

  always_ff @(posedge clk) begin
    if (!rst_n)       ctrl <= '0;
    else if (ctrl_wr) ctrl <= ctrl_new;
  end

  // a wrap in the same cycle beats the clearing write
  always_ff @(posedge clk) begin
    if (!rst_n)        ovf_flag <= 1'b0;
    else if (wrap)     ovf_flag <= 1'b1;
    else if (stat_clr) ovf_flag <= 1'b0;
  end

  always_comb begin
    unique case (addr)
      ADDR_COUNT: reg_rdata = count;
      ADDR_CTRL:  reg_rdata = {{(CNT_W-CTRL_W){1'b0}}, ctrl};
      ADDR_STAT:  reg_rdata = {{(CNT_W-1){1'b0}}, ovf_flag};
      default:    reg_rdata = '0;
    endcase
  end

  assert_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> ovf_flag);

  assert_flag_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stat_clr && !wrap |=> !ovf_flag);

  assert_flag_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap && !stat_clr |=> $stable(ovf_flag));

  assert_ctrl_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> ctrl == $past(ctrl_new));

endmodule

// File: rtl/tmr_timebase.sv
module tmr_timebase #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  input  logic             cmp7_match_i,
  output logic [CNT_W-1:0] count_o,
  output logic             tick_o,
  output logic             irq_o
);

  tmr_pkg::ctrl_t   ctrl;
  logic             restart;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic             wrap;
  logic             ovf_flag;

  tmr_regs #(.CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .count     (count_o),
    .wrap      (wrap),
    .ctrl      (ctrl),
    .restart   (restart),
    .load      (load),
    .load_val  (load_val),
    .ovf_flag  (ovf_flag),
    .irq       (irq_o),
    .reg_rdata (reg_rdata)
  );

  tmr_prescaler #(
    .SEL_W     (tmr_pkg::SEL_W),
    .MAX_SHIFT (tmr_pkg::MAX_SHIFT)
  ) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (ctrl.run),
    .psel    (ctrl.psel),
    .restart (restart),
    .tick    (tick_o)
  );

  tmr_count_core #(.CNT_W(CNT_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_o),
    .load     (load),
    .load_val (load_val),
    .mod_en   (ctrl.mod_en),
    .match    (cmp7_match_i),
    .count    (count_o),
    .wrap     (wrap)
  );

  // R8: the request follows flag and enable
  assert_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ovf_flag);

  // R5: a stopped counter never strobes
  assert_no_tick_stopped_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.run |-> !tick_o);

endmodule

// File: tb/tb_tmr_timebase.sv
module tb_tmr_timebase;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  localparam int V_SEL [NV] = '{0, 1, 2, 3, 4, 5, 6, 7};
  localparam int V_RUN [NV] = '{7, 9, 13, 16, 40, 70, 64, 95};
  localparam int V_EXP [NV] = '{7, 4, 3, 2, 2, 2, 2, 2};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        cmp7_match;
  logic [15:0] count_o;
  logic        tick_o;
  logic        irq_o;
  logic        match_on = 1'b0;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign cmp7_match = match_on && (count_o == 16'd5);

  tmr_timebase dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .cmp7_match_i (cmp7_match),
    .count_o      (count_o),
    .tick_o       (tick_o),
    .irq_o        (irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a negedge; the write lands on the next posedge
  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 count", count_o, 0);
    chk("R1 irq", irq_o, 0);
    chk("R1 tick", tick_o, 0);
    rd(2'd1, v); chk("R1 ctrl", v, 0);
    rd(2'd2, v); chk("R1 flag", v, 0);
    @(negedge clk);

    // R3 divide ratio per code, reserved codes included
    for (int i = 0; i < NV; i++) begin
      wr(2'd1, 16'h0);
      wr(2'd0, 16'h0);
      wr(2'd1, 16'((V_SEL[i] << 1) | 1));
      repeat (V_RUN[i]) @(negedge clk);
      chk($sformatf("R3 code %0d", V_SEL[i]), count_o, V_EXP[i]);
    end

    // R10 load and single-access read, R2 hold while stopped
    wr(2'd1, 16'h0);
    wr(2'd0, 16'hA5C3);
    rd(2'd0, v); chk("R10 read", v, 16'hA5C3);
    repeat (5) @(negedge clk);
    chk("R2 hold", count_o, 16'hA5C3);

    // R11 control readback and unused address
    wr(2'd1, 16'h003A);
    rd(2'd1, v); chk("R11 ctrl", v, 16'h003A);
    rd(2'd3, v); chk("R11 addr3", v, 0);
    wr(2'd1, 16'h0);

    // R6 wrap sets flag; R8 gating by enable
    wr(2'd0, 16'hFFFE);
    wr(2'd1, 16'h0001);
    repeat (2) @(negedge clk);
    chk("R6 wrap count", count_o, 0);
    rd(2'd2, v); chk("R6 flag", v, 1);
    chk("R8 irq masked", irq_o, 0);
    wr(2'd1, 16'h0011);
    chk("R8 irq on", irq_o, 1);
    wr(2'd2, 16'h0000);
    rd(2'd2, v); chk("R7 zero write", v, 1);
    wr(2'd2, 16'h0001);
    rd(2'd2, v); chk("R7 clear", v, 0);
    chk("R8 irq off", irq_o, 0);

    // R5 tick strobe at divide by 2
    wr(2'd1, 16'h0);
    wr(2'd0, 16'h0);
    wr(2'd1, 16'h0003);
    n = 0;
    for (int k = 0; k < 10; k++) begin
      if (tick_o) n++;
      @(negedge clk);
    end
    chk("R5 tick count", n, 5);
    chk("R5 steps", count_o, 5);
    wr(2'd1, 16'h0);
    n = 0;
    for (int k = 0; k < 4; k++) begin
      if (tick_o) n++;
      @(negedge clk);
    end
    chk("R5 stopped", n, 0);

    // R4 code change restarts divider
    wr(2'd0, 16'h0);
    wr(2'd1, 16'h0007);
    repeat (5) @(negedge clk);
    wr(2'd1, 16'h0005);
    repeat (3) @(negedge clk);
    chk("R4 before", count_o, 0);
    @(negedge clk);
    chk("R4 first step", count_o, 1);

    // R9 modulus reset on channel 7 match
    wr(2'd1, 16'h0);
    wr(2'd0, 16'h0);
    match_on = 1'b1;
    wr(2'd1, 16'h0021);
    repeat (14) @(negedge clk);
    chk("R9 modulus", count_o, 2);
    rd(2'd2, v); chk("R6 no flag on modulus", v, 0);
    wr(2'd1, 16'h0);
    wr(2'd0, 16'h0);
    wr(2'd1, 16'h0001);
    repeat (14) @(negedge clk);
    chk("R9 ignored", count_o, 14);
    match_on = 1'b0;

    // R10 load wins over tick
    wr(2'd0, 16'h0100);
    chk("R10 load priority", count_o, 16'h0100);
    @(negedge clk);
    chk("R10 after load", count_o, 16'h0101);

    // R7 wrap and clear in one cycle: set wins
    wr(2'd1, 16'h0);
    wr(2'd0, 16'hFFFF);
    wr(2'd1, 16'h0001);
    wr(2'd2, 16'h0001);
    rd(2'd2, v); chk("R7 set wins", v, 1);
    wr(2'd2, 16'h0001);
    rd(2'd2, v); chk("R7 cleared", v, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule